// File: doc/BRIEF.md
# Sleep-Mode Wake Request Qualifier

This block watches two lines while a bus transceiver sleeps and decides when either line has made a genuine wake request. The first line is the bus receiver level (high means recessive, low means dominant). The second is a local wake input, normally tied to a switch that pulls it low. Both lines are brought into the clock domain through a two-stage synchroniser before any edge or level is judged.

A remote request counts only when the bus falls, stays dominant for at least the bus filter time and then returns to recessive. The request is issued on that return edge. A local request counts when the wake input falls and stays low for the local filter time. The request is issued while the input is still low. After a local request, and after reset or disable, the wake input must be seen high for a qualifying period before another falling edge can start a new local request. A switch stuck low therefore produces at most one request.

Each accepted request appears as a one-cycle pulse with a source tag. A disable input, driven whenever the transceiver is not in sleep mode, clears both detectors and blocks all pulses. All filter times are parameters counted in clock cycles.

Top module: `wake_qualifier`

## Requirements
- R1: While reset is held and in the first cycle after it, `wake_valid` is 0 and `wake_src` is 0.
- R2: A bus fall followed by at least `BUS_FILT_CYC` consecutive dominant samples and then a recessive sample gives exactly one `wake_valid` pulse with `wake_src` = 0 (remote). The pulse becomes visible on the third rising clock edge after the bus input returns high.
- R3: A dominant period shorter than `BUS_FILT_CYC` samples gives no pulse. A long dominant period gives no pulse until the bus returns recessive.
- R4: A fall on the wake input followed by `LOC_FILT_CYC` consecutive low samples gives exactly one pulse with `wake_src` = 1 (local). The pulse becomes visible on the (`LOC_FILT_CYC`+2)-th rising edge after the input goes low, while the input is still low.
- R5: A wake input low period shorter than `LOC_FILT_CYC` samples gives no pulse.
- R6: A single high sample during a bus dominant qualification or a wake-low qualification restarts that detector. The total low time before and after the glitch does not add up.
- R7: After a local request, after reset and after disable, the wake input must be high for `REARM_CYC` consecutive samples before a fall can start a local request. A wake input that stays low gives no further pulse, and a high period of `REARM_CYC`-1 samples does not re-arm.
- R8: If both detectors qualify in the same cycle, a single pulse is issued with `wake_src` = 1. The remote request in that cycle is dropped.
- R9: While `detect_off` is 1, no pulse is issued and both detectors return to their initial state. A bus line that is already dominant when `detect_off` falls needs a fresh fall to count.
- R10: Each accepted request raises `wake_valid` for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| detect_off | input | 1 | 1 when the transceiver is not sleeping; clears and blocks both detectors |
| bus_rx_in | input | 1 | Asynchronous bus receiver level, 1 = recessive, 0 = dominant |
| wake_pin_in | input | 1 | Asynchronous local wake input, active low |
| wake_valid | output | 1 | One-cycle pulse for each accepted wake request |
| wake_src | output | 1 | Source of the last request: 0 = remote (bus), 1 = local (wake input) |

## Verification
A remote pulse is due on the third rising edge after the bus input is released. Two of those edges are the synchroniser and one is the output register. A local pulse is due on the (`LOC_FILT_CYC`+2)-th rising edge after the wake input first goes low. The directed tests drive inputs on falling edges and count exactly these edges before sampling `wake_valid`. They also check that it is low one edge earlier and one edge later. The table-driven tests only count pulses over a window that safely covers the due cycle, so they test acceptance and rejection at the filter boundaries apart from timing.

// File: rtl/wkq_pkg.sv
`timescale 1ns/1ps
// Package: wkq_pkg
// Shared types for the wake request qualifier: the source tag and the
// state encodings of the two detectors. No assumptions beyond 1800-2017.
package wkq_pkg;

    typedef enum logic {
        SRC_REMOTE = 1'b0,
        SRC_LOCAL  = 1'b1
    } wake_src_e;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_QUAL  = 2'd1,
        B_ARMED = 2'd2
    } bus_st_e;

    typedef enum logic [1:0] {
        L_REARM = 2'd0,
        L_IDLE  = 2'd1,
        L_QUAL  = 2'd2
    } loc_st_e;

endpackage

// File: rtl/wkq_sync.sv
`timescale 1ns/1ps
// Module: wkq_sync
// Multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 2. The chain resets to RST_VAL, so a line must be
// seen at its opposite level before any edge derived from it counts.
module wkq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/wkq_bus_det.sv
`timescale 1ns/1ps
// Module: wkq_bus_det
// Remote wake detector. It waits for a recessive-to-dominant fall,
// counts dominant samples up to FILT_CYC, then reports a hit in the
// cycle the level returns recessive. A recessive sample before the count
// completes restarts the search.
// Assumes lvl is already synchronised and FILT_CYC >= 2.
module wkq_bus_det
    import wkq_pkg::*;
#(
    parameter int FILT_CYC = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic lvl,
    output logic hit
);

    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    bus_st_e        st;
    logic [CW-1:0]  cnt;
    logic           prev;

    // Track the previous sample and step the qualification state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= B_IDLE;
            cnt  <= '0;
            prev <= 1'b0;
        end else begin
            prev <= lvl;
            if (clear) begin
                st  <= B_IDLE;
                cnt <= '0;
            end else begin
                case (st)
                    B_IDLE: begin
                        if (prev && !lvl) begin
                            st  <= B_QUAL;
                            cnt <= CW'(1);
                        end
                    end
                    B_QUAL: begin
                        if (lvl) begin
                            st  <= B_IDLE;
                            cnt <= '0;
                        end else if (cnt == LAST) begin
                            st <= B_ARMED;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    B_ARMED: begin
                        if (lvl) begin
                            st  <= B_IDLE;
                            cnt <= '0;
                        end
                    end
                    default: begin
                        st  <= B_IDLE;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    // A hit is the recessive sample that ends a qualified dominant period.
    assign hit = (st == B_ARMED) && lvl;

    // R2: the dominant counter never passes its limit.
    p_bus_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R3: the armed state is reached only from a completed count.
    p_bus_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_ARMED && $past(st) != B_ARMED) |->
            ($past(st) == B_QUAL && $past(cnt) == LAST && !$past(lvl)));

    // R9: a clear leaves the detector idle.
    p_bus_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st == B_IDLE));

    // R10: one hit per qualified period.
    p_bus_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/wkq_loc_det.sv
`timescale 1ns/1ps
// Module: wkq_loc_det
// Local wake detector. It first needs REARM_CYC consecutive high
// samples to arm. Once armed, a fall followed by FILT_CYC low samples
// gives a hit, and the detector must then re-arm. A high sample during
// qualification restarts the re-arm count from that sample.
// Assumes lvl is synchronised, FILT_CYC >= 2 and REARM_CYC >= 2.
module wkq_loc_det
    import wkq_pkg::*;
#(
    parameter int FILT_CYC  = 1750,
    parameter int REARM_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic lvl,
    output logic hit
);

    localparam int MAXC = (FILT_CYC > REARM_CYC) ? FILT_CYC : REARM_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] QLAST = CW'(FILT_CYC - 1);
    localparam logic [CW-1:0] RLAST = CW'(REARM_CYC - 1);

    loc_st_e        st;
    logic [CW-1:0]  cnt;
    logic           prev;
    logic           qual_done;

    assign qual_done = (st == L_QUAL) && !lvl && (cnt == QLAST);

    // Step the re-arm, wait and qualify phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= L_REARM;
            cnt  <= '0;
            prev <= 1'b0;
        end else begin
            prev <= lvl;
            if (clear) begin
                st  <= L_REARM;
                cnt <= '0;
            end else begin
                case (st)
                    L_REARM: begin
                        if (!lvl) begin
                            cnt <= '0;
                        end else if (cnt == RLAST) begin
                            st  <= L_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    L_IDLE: begin
                        if (prev && !lvl) begin
                            st  <= L_QUAL;
                            cnt <= CW'(1);
                        end
                    end
                    L_QUAL: begin
                        if (lvl) begin
                            st  <= L_REARM;
                            cnt <= CW'(1);
                        end else if (qual_done) begin
                            st  <= L_REARM;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: begin
                        st  <= L_REARM;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign hit = qual_done;

    // R6: qualification starts only from the armed state on a fall.
    p_loc_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_QUAL && $past(st) != L_QUAL) |->
            ($past(st) == L_IDLE && $past(prev) && !$past(lvl)));

    // R7: arming needs a full run of high samples.
    p_loc_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_IDLE && $past(st) != L_IDLE) |->
            ($past(st) == L_REARM && $past(lvl) && $past(cnt) == RLAST));

    // R9: a clear sends the detector back to re-arming.
    p_loc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st == L_REARM));

    // R10: one hit per qualified low period.
    p_loc_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

endmodule

// File: rtl/wake_qualifier.sv
`timescale 1ns/1ps
// Module: wake_qualifier
// Top of the sleep-mode wake filter. It synchronises the bus level and
// the wake input, runs a remote and a local detector, and registers one
// tagged pulse per request. Local wins a tie.
// Assumes detect_off is synchronous to clk, and that the filter
// parameters, given in clock cycles, are all >= 2.
module wake_qualifier
    import wkq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int BUS_FILT_CYC = 4500,
    parameter int LOC_FILT_CYC = 1750,
    parameter int REARM_CYC    = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic detect_off,
    input  logic bus_rx_in,
    input  logic wake_pin_in,
    output logic wake_valid,
    output logic wake_src
);

    localparam int NCH = 2;

    logic [NCH-1:0] raw_lvl;
    logic [NCH-1:0] sync_lvl;
    logic           bus_hit;
    logic           loc_hit;
    logic           any_hit;
    logic           valid_q;
    wake_src_e      src_q;

    assign raw_lvl = {wake_pin_in, bus_rx_in};

    // One synchroniser per input line.
    for (genvar g = 0; g < NCH; g++) begin : g_sync
        wkq_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b0)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_lvl[g]),
            .q    (sync_lvl[g])
        );
    end

    wkq_bus_det #(
        .FILT_CYC(BUS_FILT_CYC)
    ) u_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(detect_off),
        .lvl  (sync_lvl[0]),
        .hit  (bus_hit)
    );

    wkq_loc_det #(
        .FILT_CYC (LOC_FILT_CYC),
        .REARM_CYC(REARM_CYC)
    ) u_loc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(detect_off),
        .lvl  (sync_lvl[1]),
        .hit  (loc_hit)
    );

    assign any_hit = !detect_off && (bus_hit || loc_hit);

    // Register the pulse and the tag, with the local source winning a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            src_q   <= SRC_REMOTE;
        end else begin
            valid_q <= any_hit;
            if (any_hit) begin
                src_q <= loc_hit ? SRC_LOCAL : SRC_REMOTE;
            end
        end
    end

    assign wake_valid = valid_q;
    assign wake_src   = src_q;

    // R8: a tie is reported once as local.
    p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_hit && bus_hit && !detect_off) |=> (wake_valid && wake_src == SRC_LOCAL));

    // R9: nothing is reported for a cycle where detection was off.
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        detect_off |=> !wake_valid);

endmodule

// File: tb/sim_wake_qualifier.sv
`timescale 1ns/1ps
module sim_wake_qualifier;

    localparam int BUSF  = 8;
    localparam int LOCF  = 9;
    localparam int REARM = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic detect_off = 1'b0;
    logic bus_rx_in = 1'b1;
    logic wake_pin_in = 1'b1;
    logic wake_valid;
    logic wake_src;

    int checks = 0;
    int errs = 0;
    int pulses = 0;
    logic last_src = 1'b0;
    int p0;

    always #10 clk = ~clk;

    wake_qualifier #(
        .SYNC_STAGES (2),
        .BUS_FILT_CYC(BUSF),
        .LOC_FILT_CYC(LOCF),
        .REARM_CYC   (REARM)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .detect_off (detect_off),
        .bus_rx_in  (bus_rx_in),
        .wake_pin_in(wake_pin_in),
        .wake_valid (wake_valid),
        .wake_src   (wake_src)
    );

    // Count pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wake_valid) begin
            pulses++;
            last_src = wake_src;
        end
    end

    // Vector: {kind (0 bus, 1 local), low length, expected pulse}.
    localparam logic [9:0] VEC [0:7] = '{
        {1'b0, 8'd7,  1'b0},   // R3 one short of the bus filter
        {1'b0, 8'd8,  1'b1},   // R2 exactly the bus filter
        {1'b0, 8'd20, 1'b1},   // R2 long dominant
        {1'b0, 8'd1,  1'b0},   // R3 single sample
        {1'b1, 8'd8,  1'b0},   // R5 one short of the local filter
        {1'b1, 8'd9,  1'b1},   // R4 exactly the local filter
        {1'b1, 8'd30, 1'b1},   // R4 long low
        {1'b1, 8'd2,  1'b0}    // R5 short low
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        bus_rx_in = 1'b1;
        wake_pin_in = 1'b1;
        tick(n);
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        bus_rx_in = 1'b0;
        wake_pin_in = 1'b0;
        tick(3);
        chk("R1 valid in reset", int'(wake_valid), 0);
        chk("R1 src in reset", int'(wake_src), 0);
        bus_rx_in = 1'b1;
        wake_pin_in = 1'b1;
        rst_n = 1'b1;
        tick(1);
        chk("R1 valid after reset", int'(wake_valid), 0);

        // Table walk: acceptance and rejection at the filter edges.
        for (int v = 0; v < 8; v++) begin
            idle(12);
            p0 = pulses;
            if (VEC[v][9]) wake_pin_in = 1'b0;
            else           bus_rx_in = 1'b0;
            tick(int'(VEC[v][8:1]));
            idle(8);
            chk(VEC[v][9] ? "R4/R5 vector pulses" : "R2/R3 vector pulses",
                pulses - p0, int'(VEC[v][0]));
            if (VEC[v][0]) chk("R2/R4 vector source", int'(last_src), int'(VEC[v][9]));
        end

        // R2 exact timing of a remote pulse.
        idle(12);
        bus_rx_in = 1'b0;
        tick(BUSF);
        bus_rx_in = 1'b1;
        tick(2);
        chk("R2 not yet", int'(wake_valid), 0);
        tick(1);
        chk("R2 pulse due", int'(wake_valid), 1);
        chk("R2 remote tag", int'(wake_src), 0);
        tick(1);
        chk("R10 remote pulse width", int'(wake_valid), 0);

        // R4 exact timing of a local pulse, then stuck low.
        idle(12);
        wake_pin_in = 1'b0;
        tick(LOCF + 1);
        chk("R4 not yet", int'(wake_valid), 0);
        tick(1);
        chk("R4 pulse due", int'(wake_valid), 1);
        chk("R4 local tag", int'(wake_src), 1);
        tick(1);
        chk("R10 local pulse width", int'(wake_valid), 0);
        p0 = pulses;
        tick(60);
        chk("R7 stuck low no repeat", pulses - p0, 0);

        // R7 re-arm needs REARM high samples.
        wake_pin_in = 1'b1;
        tick(REARM - 1);
        wake_pin_in = 1'b0;
        tick(20);
        chk("R7 short high does not re-arm", pulses - p0, 0);
        wake_pin_in = 1'b1;
        tick(REARM);
        wake_pin_in = 1'b0;
        tick(20);
        chk("R7 full high re-arms", pulses - p0, 1);

        // R3 long dominant waits for release.
        idle(12);
        p0 = pulses;
        bus_rx_in = 1'b0;
        tick(40);
        chk("R3 no pulse while dominant", pulses - p0, 0);
        bus_rx_in = 1'b1;
        tick(6);
        chk("R2 pulse on release", pulses - p0, 1);

        // R6 glitches restart qualification.
        idle(12);
        p0 = pulses;
        bus_rx_in = 1'b0;
        tick(5);
        bus_rx_in = 1'b1;
        tick(1);
        bus_rx_in = 1'b0;
        tick(6);
        idle(6);
        chk("R6 bus glitch restarts", pulses - p0, 0);
        idle(12);
        wake_pin_in = 1'b0;
        tick(6);
        wake_pin_in = 1'b1;
        tick(1);
        wake_pin_in = 1'b0;
        tick(8);
        idle(4);
        chk("R6 local glitch restarts", pulses - p0, 0);

        // R8 both qualify in the same cycle.
        idle(12);
        p0 = pulses;
        bus_rx_in = 1'b0;
        wake_pin_in = 1'b0;
        tick(BUSF);
        bus_rx_in = 1'b1;
        tick(2);
        chk("R8 not yet", int'(wake_valid), 0);
        tick(1);
        chk("R8 pulse", int'(wake_valid), 1);
        chk("R8 local wins", int'(wake_src), 1);
        tick(1);
        chk("R8 no second pulse", int'(wake_valid), 0);
        tick(10);
        chk("R8 one pulse total", pulses - p0, 1);

        // R9 disable blocks and clears.
        idle(12);
        p0 = pulses;
        detect_off = 1'b1;
        bus_rx_in = 1'b0;
        tick(20);
        bus_rx_in = 1'b1;
        wake_pin_in = 1'b0;
        tick(20);
        wake_pin_in = 1'b1;
        tick(6);
        chk("R9 nothing while off", pulses - p0, 0);
        detect_off = 1'b0;
        idle(12);
        bus_rx_in = 1'b0;
        tick(5);
        detect_off = 1'b1;
        tick(2);
        detect_off = 1'b0;
        tick(15);
        bus_rx_in = 1'b1;
        tick(6);
        chk("R9 dominant across disable", pulses - p0, 0);

        // R7 sleep entered with the wake input already low.
        detect_off = 1'b1;
        wake_pin_in = 1'b0;
        tick(5);
        detect_off = 1'b0;
        tick(60);
        chk("R7 low at sleep entry", pulses - p0, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule